// File: doc/BRIEF.md
# Packet Field Editor with Delay Buffer

This block sits on a 64-bit packet stream and holds every arriving word in a delay buffer. It waits there until a separate processing stage hands over a verdict for that packet. The verdict is a command plus four 32-bit field values. The buffered packets and the commands are paired strictly in arrival order.

A small microcoded sequencer carries out each command. It walks the packet header one word at a time and overwrites bit-level slots with the supplied values, then streams the untouched remainder. Instead of an edit, the command can discard the packet, or replace it with a fresh packet assembled from a template held in microcode.

The microcode has five operations: field write (1 to 32 bits at any bit offset, done as a masked read-modify-write of the current word), advance to the next word, jump if a field is zero, add an immediate to a field, and end.

Both streams use valid/ready. An input word transfers when `in_valid` and `in_ready` are both high. The sender must hold a word until it transfers. When `out_valid` is high and `out_ready` is low, the block keeps `out_valid`, `out_data` and `out_last` unchanged until the word transfers. A command transfers when `cmd_valid` and `cmd_ready` are both high.

Top module: `pkt_field_editor`

## Requirements
- R1: No word of a packet leaves the block until a command for that packet has been accepted. The head of the buffer is held for as long as it takes.
- R2: `in_ready` is low exactly when the buffer holds DEPTH words, and every accepted word is kept.
- R3: Command code 0 (edit) applies two edits. Word 0 bits [15:0] become field 0 bits [15:0]. In word 1, bits [63:32] become field 1 plus one when field 2 is nonzero (field 1 unchanged when field 2 is zero), and bits [15:8] become field 3 bits [7:0]. Every other bit is unchanged. Field i occupies `cmd_fields[32*i+31:32*i]`.
- R4: In an edit, every word after word 1 is forwarded unchanged, and the packet keeps its original `out_last` position.
- R5: An edited one-word packet leaves as a single word with only the word-0 edit applied, with `out_last` high.
- R6: Command codes 1 and 3 (drop) remove the whole packet from the buffer, and `out_valid` stays low while they run.
- R7: Command code 2 (build) discards the buffered packet and emits a new one. Word 0 is {32'hA5A50001, field 0}. Word 1 is {32'h0, field 1}. When field 2 is nonzero, a word 2 of {field 3 bits [15:0], 48'h0} follows. `out_last` is high on the final word.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` do not change.
- R9: `cmd_ready` is high only when no command is in progress, and it is high again in the cycle after the final word of a packet transfers.
- R10: After reset, `in_ready` and `cmd_ready` are high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | 64 | Input word |
| in_last | input | 1 | Final word of the packet |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_op | input | 2 | 0 edit, 1 drop, 2 build, 3 drop |
| cmd_fields | input | 128 | Four 32-bit field values |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 64 | Output word |
| out_last | output | 1 | Final word of the output packet |

## Verification
The bench aims at several corner cases:
- A one-word packet, where an edit that ignores the last flag would pull the next packet's word into this one.
- A two-word packet, which reaches the end of the program on its last word and must not fall into pass-through.
- The conditional-increment path in both directions, where a broken jump would be off by one in the upper half of word 1.
- Drop and build decisions sent back to back, where a leaking drain would emit stray words and a wrong drain would shift every later packet.
- A packet longer than the buffer, held with no command, which must make `in_ready` fall and must resume without losing words.

Random output stalls throughout catch any change of the output word while it is held.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam int DATA_W   = 64;
  localparam int FIELD_W  = 32;
  localparam int NUM_FLD  = 4;
  localparam int FSEL_W   = $clog2(NUM_FLD);
  localparam int PC_W     = 4;
  localparam int OFF_W    = $clog2(DATA_W);
  localparam int WID_W    = $clog2(FIELD_W);
  localparam logic [PC_W-1:0] BUILD_ENTRY = 4'd8;

  typedef enum logic [1:0] {
    CMD_EDIT  = 2'd0,
    CMD_DROP  = 2'd1,
    CMD_BUILD = 2'd2,
    CMD_DROP2 = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    UOP_WR  = 3'd0,
    UOP_ADV = 3'd1,
    UOP_JZ  = 3'd2,
    UOP_ADD = 3'd3,
    UOP_END = 3'd4
  } uop_e;

  typedef struct packed {
    uop_e               op;
    logic               use_imm;
    logic [FSEL_W-1:0]  fsel;
    logic [OFF_W-1:0]   off;
    logic [WID_W-1:0]   wm1;     // field width minus one
    logic [FIELD_W-1:0] imm;
    logic [PC_W-1:0]    tgt;
  } uinstr_t;

  // Masked insertion of a field of (wm1+1) bits at bit offset off.
  function automatic logic [DATA_W-1:0] put_field(
      input logic [DATA_W-1:0]  word,
      input logic [FIELD_W-1:0] val,
      input logic [OFF_W-1:0]   off,
      input logic [WID_W-1:0]   wm1);
    logic [FIELD_W:0]  ones;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] ins;
    ones = ({{FIELD_W{1'b0}}, 1'b1} << ({1'b0, wm1} + 1'b1)) - 1'b1;
    mask = {{(DATA_W-FIELD_W){1'b0}}, ones[FIELD_W-1:0]} << off;
    ins  = {{(DATA_W-FIELD_W){1'b0}}, val} << off;
    return (word & ~mask) | (ins & mask);
  endfunction
endpackage

// File: rtl/pfe_delay_fifo.sv
module pfe_delay_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push;

  assign push_ready = (count != CW'(DEPTH));
  assign empty      = (count == '0);
  assign push       = push_valid && push_ready;
  assign head       = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/pfe_ucode_rom.sv
module pfe_ucode_rom
  import pfe_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  output uinstr_t         ui
);
  function automatic uinstr_t mk(uop_e op, logic use_imm, logic [FSEL_W-1:0] fsel,
                                 int off, int width, logic [FIELD_W-1:0] imm, int tgt);
    uinstr_t u;
    u.op      = op;
    u.use_imm = use_imm;
    u.fsel    = fsel;
    u.off     = OFF_W'(off);
    u.wm1     = WID_W'(width - 1);
    u.imm     = imm;
    u.tgt     = PC_W'(tgt);
    return u;
  endfunction

  always_comb begin
    unique case (pc)
      // edit program
      4'd0:  ui = mk(UOP_WR,  1'b0, 2'd0, 0,  16, '0, 0);
      4'd1:  ui = mk(UOP_ADV, 1'b0, 2'd0, 0,  1,  '0, 0);
      4'd2:  ui = mk(UOP_JZ,  1'b0, 2'd2, 0,  1,  '0, 4);
      4'd3:  ui = mk(UOP_ADD, 1'b1, 2'd1, 0,  1,  32'd1, 0);
      4'd4:  ui = mk(UOP_WR,  1'b0, 2'd1, 32, 32, '0, 0);
      4'd5:  ui = mk(UOP_WR,  1'b0, 2'd3, 8,  8,  '0, 0);
      4'd6:  ui = mk(UOP_END, 1'b0, 2'd0, 0,  1,  '0, 0);
      4'd7:  ui = mk(UOP_END, 1'b0, 2'd0, 0,  1,  '0, 0);
      // template program
      4'd8:  ui = mk(UOP_WR,  1'b1, 2'd0, 32, 32, 32'hA5A5_0001, 0);
      4'd9:  ui = mk(UOP_WR,  1'b0, 2'd0, 0,  32, '0, 0);
      4'd10: ui = mk(UOP_ADV, 1'b0, 2'd0, 0,  1,  '0, 0);
      4'd11: ui = mk(UOP_WR,  1'b0, 2'd1, 0,  32, '0, 0);
      4'd12: ui = mk(UOP_JZ,  1'b0, 2'd2, 0,  1,  '0, 15);
      4'd13: ui = mk(UOP_ADV, 1'b0, 2'd0, 0,  1,  '0, 0);
      4'd14: ui = mk(UOP_WR,  1'b0, 2'd3, 48, 16, '0, 0);
      default: ui = mk(UOP_END, 1'b0, 2'd0, 0, 1, '0, 0);
    endcase
  end
endmodule

// File: rtl/pfe_engine.sv
module pfe_engine
  import pfe_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [NUM_FLD*FIELD_W-1:0] cmd_fields,
  input  logic                       fifo_empty,
  input  logic [DATA_W:0]            fifo_head,
  output logic                       fifo_pop,
  output logic [PC_W-1:0]            pc,
  input  uinstr_t                    ui,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_last
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_EXEC, S_EMIT, S_PASS, S_DRAIN} st_e;

  st_e                st;
  logic [DATA_W-1:0]  cur;
  logic               cur_last, at_end, building, then_build;
  logic [FIELD_W-1:0] fld      [NUM_FLD];
  logic [FIELD_W-1:0] field_in [NUM_FLD];
  logic [FIELD_W-1:0] sel_val;
  logic               head_last;
  logic [DATA_W-1:0]  head_data;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_unpack
    assign field_in[g] = cmd_fields[g*FIELD_W +: FIELD_W];
  end

  assign head_last = fifo_head[DATA_W];
  assign head_data = fifo_head[DATA_W-1:0];
  assign sel_val   = ui.use_imm ? ui.imm : fld[ui.fsel];

  always_comb begin
    cmd_ready = (st == S_IDLE);
    out_valid = (st == S_EMIT) || (st == S_PASS && !fifo_empty);
    out_data  = (st == S_PASS) ? head_data : cur;
    out_last  = (st == S_PASS) ? head_last : (building ? at_end : cur_last);
    fifo_pop  = !fifo_empty && ((st == S_LOAD) || (st == S_DRAIN) ||
                                (st == S_PASS && out_ready));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pc         <= '0;
      cur        <= '0;
      cur_last   <= 1'b0;
      at_end     <= 1'b0;
      building   <= 1'b0;
      then_build <= 1'b0;
      for (int i = 0; i < NUM_FLD; i++) fld[i] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          for (int i = 0; i < NUM_FLD; i++) fld[i] <= field_in[i];
          building   <= 1'b0;
          then_build <= (cmd_op == CMD_BUILD);
          pc         <= '0;
          st         <= (cmd_op == CMD_EDIT) ? S_LOAD : S_DRAIN;
        end
        S_LOAD: if (!fifo_empty) begin
          cur      <= head_data;
          cur_last <= head_last;
          st       <= S_EXEC;
        end
        S_EXEC: begin
          unique case (ui.op)
            UOP_WR: begin
              cur <= put_field(cur, sel_val, ui.off, ui.wm1);
              pc  <= pc + 1'b1;
            end
            UOP_ADD: begin
              fld[ui.fsel] <= fld[ui.fsel] + ui.imm;
              pc           <= pc + 1'b1;
            end
            UOP_JZ:  pc <= (fld[ui.fsel] == '0) ? ui.tgt : pc + 1'b1;
            UOP_ADV: begin at_end <= 1'b0; st <= S_EMIT; end
            default: begin at_end <= 1'b1; st <= S_EMIT; end
          endcase
        end
        S_EMIT: if (out_ready) begin
          if (building) begin
            if (at_end) st <= S_IDLE;
            else begin cur <= '0; pc <= pc + 1'b1; st <= S_EXEC; end
          end else if (cur_last) st <= S_IDLE;
          else if (at_end)       st <= S_PASS;
          else begin pc <= pc + 1'b1; st <= S_LOAD; end
        end
        S_PASS: if (!fifo_empty && out_ready && head_last) st <= S_IDLE;
        S_DRAIN: if (!fifo_empty && head_last) begin
          if (then_build) begin
            building <= 1'b1;
            cur      <= '0;
            pc       <= BUILD_ENTRY;
            st       <= S_EXEC;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> cmd_ready);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !out_valid && !fifo_pop);
  a_r6_drain_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN) |-> !out_valid);
endmodule

// File: rtl/pkt_field_editor.sv
module pkt_field_editor
  import pfe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_last,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [NUM_FLD*FIELD_W-1:0] cmd_fields,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_last
);
  logic            fifo_empty, fifo_pop;
  logic [DATA_W:0] fifo_head;
  logic [PC_W-1:0] pc;
  uinstr_t         ui;

  pfe_delay_fifo #(.DEPTH(DEPTH), .W(DATA_W+1)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_ready (in_ready),
    .push_word  ({in_last, in_data}),
    .pop        (fifo_pop),
    .empty      (fifo_empty),
    .head       (fifo_head)
  );

  pfe_ucode_rom u_rom (
    .pc (pc),
    .ui (ui)
  );

  pfe_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_fields (cmd_fields),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .fifo_pop   (fifo_pop),
    .pc         (pc),
    .ui         (ui),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
  );
endmodule

// File: tb/tb_pkt_field_editor.sv
module tb_pkt_field_editor;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [63:0]  in_data = '0;
  logic         cmd_valid = 1'b0, cmd_ready;
  logic [1:0]   cmd_op = '0;
  logic [127:0] cmd_fields = '0;
  logic         out_valid, out_last;
  logic         out_ready = 1'b1;
  logic [63:0]  out_data;

  always #4 clk = ~clk;

  pkt_field_editor #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_fields(cmd_fields),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, failures = 0, cyc = 0;
  logic [64:0]  in_q[$], mdl_q[$], exp_q[$];
  string        tag_q[$];
  logic [129:0] cmd_q[$], pend_q[$];
  bit           chk_en = 0, rnd_ready = 0, mdl_act = 0, last_drop = 0;
  logic [1:0]   m_op;
  logic [31:0]  m_f[4];
  int           m_idx;
  logic [15:0]  lfsr = 16'hACE1;
  bit           stall_prev = 0;
  logic [64:0]  prev_out;

  task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [63:0] edit_word(logic [63:0] w, int idx, logic [31:0] f[4]);
    logic [63:0] r = w;
    if (idx == 0) r[15:0] = f[0][15:0];
    if (idx == 1) begin
      r[63:32] = f[1] + ((f[2] != 0) ? 32'd1 : 32'd0);
      r[15:8]  = f[3][7:0];
    end
    return r;
  endfunction

  task automatic model_step();
    bit progress = 1;
    while (progress) begin
      progress = 0;
      if (!mdl_act && pend_q.size() > 0) begin
        logic [129:0] c = pend_q.pop_front();
        m_op = c[129:128];
        for (int i = 0; i < 4; i++) m_f[i] = c[i*32 +: 32];
        m_idx = 0; mdl_act = 1; progress = 1;
        last_drop = (m_op == 2'd1 || m_op == 2'd3);
      end
      if (mdl_act && mdl_q.size() > 0) begin
        logic [64:0] w = mdl_q.pop_front();
        progress = 1;
        if (m_op == 2'd0) begin
          exp_q.push_back({w[64], edit_word(w[63:0], m_idx, m_f)});
          tag_q.push_back((m_idx == 0 && w[64]) ? "R5" : (m_idx < 2 ? "R3" : "R4"));
        end
        m_idx++;
        if (w[64]) begin
          mdl_act = 0;
          if (m_op == 2'd2) begin   // R7 template
            exp_q.push_back({1'b0, 32'hA5A50001, m_f[0]}); tag_q.push_back("R7");
            exp_q.push_back({(m_f[2] == 0), 32'h0, m_f[1]}); tag_q.push_back("R7");
            if (m_f[2] != 0) begin
              exp_q.push_back({1'b1, m_f[3][15:0], 48'h0}); tag_q.push_back("R7");
            end
          end
        end
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    in_valid = in_q.size() > 0;
    {in_last, in_data} = in_valid ? in_q[0] : 65'h0;
    cmd_valid = cmd_q.size() > 0;
    {cmd_op, cmd_fields} = cmd_valid ? cmd_q[0] : 130'h0;
    out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #3;
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", 65'(cyc), 65'd0);
      finish_run();
    end
    if (chk_en) begin
      if (exp_q.size() > 0) chk(cmd_ready == 1'b0, "R9 busy", 65'(cmd_ready), 65'd0);
      if (cmd_ready && !mdl_act)
        chk(in_ready == (mdl_q.size() < DEPTH), "R2 in_ready", 65'(in_ready),
            65'(mdl_q.size() < DEPTH));
      if (stall_prev)
        chk(out_valid && {out_last, out_data} == prev_out, "R8 stall hold",
            {out_last, out_data}, prev_out);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(0, last_drop ? "R6 stray word" : "R1 early word", {out_last, out_data}, 65'h0);
        else begin
          logic [64:0] e = exp_q.pop_front();
          string t = tag_q.pop_front();
          chk({out_last, out_data} == e, t, {out_last, out_data}, e);
        end
      end
    end
    stall_prev = out_valid && !out_ready;
    prev_out   = {out_last, out_data};
    if (in_valid && in_ready) mdl_q.push_back(in_q.pop_front());
    if (cmd_valid && cmd_ready) pend_q.push_back(cmd_q.pop_front());
    model_step();
  endtask

  task automatic wait_done();
    while (in_q.size() || cmd_q.size() || pend_q.size() || mdl_act || exp_q.size() || !cmd_ready)
      tick();
    repeat (3) tick();
  endtask

  task automatic add_pkt(int n, logic [63:0] base);
    for (int i = 0; i < n; i++)
      in_q.push_back({(i == n-1), base + 64'(i) * 64'h0101_0101_0101_0101});
  endtask

  task automatic add_cmd(logic [1:0] op, logic [31:0] f0, f1, f2, f3);
    cmd_q.push_back({op, f3, f2, f1, f0});
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(in_ready == 1'b1, "R10 in_ready", 65'(in_ready), 65'd1);
    chk(cmd_ready == 1'b1, "R10 cmd_ready", 65'(cmd_ready), 65'd1);
    chk(out_valid == 1'b0, "R10 out_valid", 65'(out_valid), 65'd0);
    chk_en = 1;

    // R1: packet held until its command arrives
    add_pkt(5, 64'h1122_3344_5566_7788);
    repeat (12) begin
      tick();
      chk(out_valid == 1'b0, "R1 held", 65'(out_valid), 65'd0);
    end
    rnd_ready = 1;
    add_cmd(2'd0, 32'hDEAD_BEEF, 32'h0000_0010, 32'd5, 32'h0000_0077);   // R3 R4 increment path
    wait_done();

    add_pkt(1, 64'hCAFE_0000_F00D_0001);                                  // R5
    add_cmd(2'd0, 32'h0000_ABCD, 32'h1, 32'd0, 32'h5);
    add_pkt(2, 64'h0F0F_0F0F_0F0F_0F0F);                                  // R3 no-increment path
    add_cmd(2'd0, 32'h1234_5678, 32'hFFFF_FFFE, 32'd0, 32'hC3);
    wait_done();

    add_pkt(3, 64'h7777_0000_1111_0000);                                  // R6 drop code 1
    add_cmd(2'd1, 32'h0, 32'h0, 32'h0, 32'h0);
    add_pkt(4, 64'h5555_AAAA_5555_AAAA);                                  // R6 drop code 3
    add_cmd(2'd3, 32'h0, 32'h0, 32'h0, 32'h0);
    add_pkt(3, 64'h0000_0000_0000_0100);
    add_cmd(2'd0, 32'h0000_9999, 32'h7FFF_FFFF, 32'd1, 32'hEE);
    wait_done();

    add_pkt(2, 64'h8888_9999_AAAA_BBBB);                                  // R7 three words
    add_cmd(2'd2, 32'h0102_0304, 32'h0506_0708, 32'd9, 32'h0000_BEEF);
    add_pkt(4, 64'h3333_4444_5555_6666);                                  // R7 two words
    add_cmd(2'd2, 32'hFACE_FACE, 32'h0BAD_F00D, 32'd0, 32'h1234);
    wait_done();

    // R2: longer than the buffer, no command yet
    rnd_ready = 0;
    add_pkt(DEPTH + 6, 64'h0123_4567_89AB_CDEF);
    repeat (DEPTH + 10) tick();
    chk(in_ready == 1'b0, "R2 full", 65'(in_ready), 65'd0);
    chk(in_q.size() == 6, "R2 stalled words", 65'(in_q.size()), 65'd6);
    rnd_ready = 1;
    add_cmd(2'd0, 32'h0000_4242, 32'h0000_0100, 32'd3, 32'h0000_0011);
    wait_done();

    chk(exp_q.size() == 0, "R4 all delivered", 65'(exp_q.size()), 65'd0);
    finish_run();
  end
endmodule